// File: doc/BRIEF.md
# TDM Receive Slot Selector

This block takes one serial audio lane made of a bit clock, a frame sync and a data line. It splits each frame into fixed-length time slots and extracts the single playback sample that the configuration asks for. The bit clock, frame sync and data inputs arrive already synchronised to the fast system clock `clk`. The block finds the chosen bit-clock edge by comparing successive samples of the bit clock. This keeps the whole design in one clock domain, and choosing the capture edge becomes a choice between a rising-edge and a falling-edge detector.

Each frame starts on a frame-sync transition of a chosen polarity. Slot 0 begins a programmable number of bit clocks after that transition. The block captures the selected slot, or the left and right slots together, and cuts the audio word out of the slot using the word length and the justification. It returns the word as a signed 32-bit value whose MSB sits at bit 31. The block measures each frame's length itself, so it can only judge a slot once the frame has ended. At the next frame start it emits the result with a one-cycle valid strobe. A slot that does not fit inside the measured frame is reported through a null flag and replaced by silence. The configuration is meant to change only while reset is asserted.

Top module: `tdm_rx_slot_selector`

## Requirements
- R1: A frame starts at a frame-sync transition seen on a capture edge. When `cfg_fs_fall_i`=1 the transition is high-to-low, and when it is 0 the transition is low-to-high. The bit on which that transition is seen is frame position 0.
- R2: Frame sync and data are sampled on rising bit-clock edges when `cfg_cap_fall_i`=0 and on falling bit-clock edges when it is 1.
- R3: Slot n covers frame positions from `cfg_offset_i` + n*S up to and including `cfg_offset_i` + n*S + S - 1, where S is the slot length and the offset runs from 0 to 31. The bit at the lowest position is the slot MSB.
- R4: Slot length code `cfg_slot_len_i`: 00 gives 16 bits, 01 gives 24, 10 gives 32, and 11 (reserved) is treated as 32.
- R5: Word length code `cfg_word_len_i`: 00 gives 16 bits, 01 gives 20, 10 gives 24 and 11 gives 32. The effective word length W is the smaller of the word length and S. The word leaves the block with its MSB at bit 31 of `smp_o`, and the 32-W bits below it are zero.
- R6: When `cfg_right_just_i`=0 the word is the top W bits of the slot. When it is 1 the word is the bottom W bits of the slot.
- R7: Source code `cfg_src_i`: 00 outputs slot `dev_slot_i`, 01 outputs slot `cfg_left_slot_i`, and 10 outputs slot `cfg_right_slot_i`.
- R8: Source code 11 outputs the sum of the left and right words, taken as signed 32-bit values, shifted right arithmetically by one (rounding toward minus infinity).
- R9: A slot whose last position is at or beyond the measured frame length yields a zero word and raises `smp_null_o`. A slot that ends exactly at the frame's last position is valid. In mode 11 a null slot contributes zero, and the flag is raised if either slot is null.
- R10: During reset all outputs are zero. `smp_valid_o` is a single-cycle pulse issued once per frame start, carrying the previous frame's result. No pulse is issued at the first frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, synchronised to `clk` |
| fsync_i | input | 1 | Frame sync, synchronised to `clk` |
| sdata_i | input | 1 | Serial data, synchronised to `clk` |
| cfg_fs_fall_i | input | 1 | 1: frame starts on falling sync, 0: on rising sync |
| cfg_cap_fall_i | input | 1 | 1: capture on falling bit-clock edge, 0: rising |
| cfg_offset_i | input | 5 | Bit clocks from frame start to slot 0 |
| cfg_slot_len_i | input | 2 | Slot length code |
| cfg_word_len_i | input | 2 | Word length code |
| cfg_right_just_i | input | 1 | 1: word at slot LSB end, 0: at slot MSB end |
| cfg_src_i | input | 2 | Output source code |
| cfg_left_slot_i | input | 4 | Left slot number |
| cfg_right_slot_i | input | 4 | Right slot number |
| dev_slot_i | input | 4 | Slot number for source code 00 |
| smp_o | output | 32 | Signed sample, MSB-aligned |
| smp_valid_o | output | 1 | One-cycle strobe when `smp_o` is updated |
| smp_null_o | output | 1 | Selected slot fell outside the frame |

## Verification
A wrong bit position or a wrong window start shows up in the first emitted sample as a word shifted by one or more bits. That sample appears one frame after the frame it came from. A frame-length counter that is off by one shows up only on slots that end exactly at the frame boundary, so the bench puts a slot right on that boundary and one bit past it. An error in the arming of the frame tracker shows up at once, either as a valid pulse at the first frame start or as a missing pulse at the second. Any drift in the capture edge or the polarity corrupts every word of that configuration.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;

  typedef enum logic [1:0] {
    SRC_DEV   = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_MIX   = 2'b11
  } src_sel_e;

  localparam int unsigned SAMPLE_W = 32;

  // slot length code to bit count (reserved code treated as widest slot)
  function automatic logic [5:0] slot_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // word length code to bit count
  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // a word never extends past its slot
  function automatic logic [5:0] eff_bits(input logic [5:0] sbits, input logic [5:0] wbits);
    return (wbits < sbits) ? wbits : sbits;
  endfunction

endpackage

// File: rtl/tdmrx_bit_sampler.sv
module tdmrx_bit_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdata_i,
  input  logic cap_fall_i,
  output logic bit_stb_o,
  output logic fs_bit_o,
  output logic sd_bit_o
);

  logic bclk_q;
  logic stb_d, stb_q;
  logic fs_q, sd_q;

  // edge detector on the oversampled bit clock
  always_comb begin
    if (cap_fall_i) stb_d = bclk_q & ~bclk_i;
    else            stb_d = ~bclk_q & bclk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      stb_q  <= stb_d;
      if (stb_d) begin
        fs_q <= fsync_i;
        sd_q <= sdata_i;
      end
    end
  end

  assign bit_stb_o = stb_q;
  assign fs_bit_o  = fs_q;
  assign sd_bit_o  = sd_q;

  // one bit-clock edge needs two clk samples, so strobes never touch
  p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/tdmrx_frame_tracker.sv
module tdmrx_frame_tracker #(
  parameter int unsigned MAX_FRAME_BITS = 1024,
  localparam int unsigned PW = $clog2(MAX_FRAME_BITS),
  localparam int unsigned LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb_i,
  input  logic          fs_bit_i,
  input  logic          fs_fall_i,
  output logic          start_o,
  output logic          emit_o,
  output logic [PW-1:0] pos_o,
  output logic [LW-1:0] len_o
);

  localparam logic [PW-1:0] POS_MAX = PW'(MAX_FRAME_BITS - 1);

  logic          have_prev_q, fs_prev_q, armed_q;
  logic [PW-1:0] cnt_q;
  logic          start;
  logic [PW-1:0] pos_d;

  always_comb begin
    start = 1'b0;
    if (bit_stb_i && have_prev_q) begin
      if (fs_fall_i) start = fs_prev_q & ~fs_bit_i;
      else           start = ~fs_prev_q & fs_bit_i;
    end
    if (start)                pos_d = '0;
    else if (cnt_q == POS_MAX) pos_d = cnt_q;
    else                       pos_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      fs_prev_q   <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
    end else if (bit_stb_i) begin
      have_prev_q <= 1'b1;
      fs_prev_q   <= fs_bit_i;
      cnt_q       <= pos_d;
      if (start) armed_q <= 1'b1;
    end
  end

  assign start_o = start;
  assign emit_o  = start & armed_q;
  assign pos_o   = pos_d;
  // length of the frame that ends at this start: last position plus one
  assign len_o   = LW'(cnt_q) + LW'(1);

endmodule

// File: rtl/tdmrx_slot_capture.sv
module tdmrx_slot_capture #(
  parameter int unsigned PW = 10,
  parameter int unsigned LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb_i,
  input  logic          sd_bit_i,
  input  logic          start_i,
  input  logic [PW-1:0] pos_i,
  input  logic [LW-1:0] len_i,
  input  logic [3:0]    slot_i,
  input  logic [4:0]    offset_i,
  input  logic [5:0]    slot_bits_i,
  input  logic [5:0]    eff_bits_i,
  input  logic          right_just_i,
  output logic [31:0]   word_o,
  output logic          null_o
);

  localparam int unsigned EW = 16;

  logic [31:0]   shreg_q, shreg_d;
  logic [EW-1:0] win_lo, win_hi, pos_x, len_x;
  logic          in_win;
  logic [31:0]   aligned, keep;

  always_comb begin
    pos_x  = EW'(pos_i);
    len_x  = EW'(len_i);
    win_lo = EW'(offset_i) + EW'(slot_i) * EW'(slot_bits_i);
    win_hi = win_lo + EW'(slot_bits_i);
    in_win = (pos_x >= win_lo) && (pos_x < win_hi);
  end

  // next-state of the slot shift register
  always_comb begin
    shreg_d = shreg_q;
    if (bit_stb_i) begin
      if (start_i)     shreg_d = in_win ? {31'd0, sd_bit_i} : 32'd0;
      else if (in_win) shreg_d = {shreg_q[30:0], sd_bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  // word extraction from the finished slot (valid at frame start)
  always_comb begin
    if (right_just_i) aligned = shreg_q << (6'd32 - eff_bits_i);
    else              aligned = shreg_q << (6'd32 - slot_bits_i);
    keep   = ~(32'hFFFF_FFFF >> eff_bits_i);
    null_o = win_hi > len_x;
    word_o = null_o ? 32'd0 : (aligned & keep);
  end

  // a new frame leaves at most its first bit in the window register
  p_window_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb_i && start_i) |=> (shreg_q[31:1] == 31'd0));

endmodule

// File: rtl/tdm_rx_slot_selector.sv
module tdm_rx_slot_selector
  import tdmrx_pkg::*;
#(
  parameter int unsigned MAX_FRAME_BITS = 1024,
  parameter int unsigned NUM_CH         = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_i,
  input  logic        fsync_i,
  input  logic        sdata_i,
  input  logic        cfg_fs_fall_i,
  input  logic        cfg_cap_fall_i,
  input  logic [4:0]  cfg_offset_i,
  input  logic [1:0]  cfg_slot_len_i,
  input  logic [1:0]  cfg_word_len_i,
  input  logic        cfg_right_just_i,
  input  logic [1:0]  cfg_src_i,
  input  logic [3:0]  cfg_left_slot_i,
  input  logic [3:0]  cfg_right_slot_i,
  input  logic [3:0]  dev_slot_i,
  output logic [31:0] smp_o,
  output logic        smp_valid_o,
  output logic        smp_null_o
);

  localparam int unsigned PW = $clog2(MAX_FRAME_BITS);
  localparam int unsigned LW = PW + 1;

  // reset: asserted asynchronously, released on clk
  logic rst_meta_q, rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_l      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_l      <= rst_meta_q;
    end
  end

  src_sel_e    src;
  logic [5:0]  sbits, ebits;
  logic        bit_stb, fs_bit, sd_bit;
  logic        start, emit;
  logic [PW-1:0] pos;
  logic [LW-1:0] flen;

  assign src   = src_sel_e'(cfg_src_i);
  assign sbits = slot_bits(cfg_slot_len_i);
  assign ebits = eff_bits(sbits, word_bits(cfg_word_len_i));

  tdmrx_bit_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_l),
    .bclk_i    (bclk_i),
    .fsync_i   (fsync_i),
    .sdata_i   (sdata_i),
    .cap_fall_i(cfg_cap_fall_i),
    .bit_stb_o (bit_stb),
    .fs_bit_o  (fs_bit),
    .sd_bit_o  (sd_bit)
  );

  tdmrx_frame_tracker #(.MAX_FRAME_BITS(MAX_FRAME_BITS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_l),
    .bit_stb_i(bit_stb),
    .fs_bit_i (fs_bit),
    .fs_fall_i(cfg_fs_fall_i),
    .start_o  (start),
    .emit_o   (emit),
    .pos_o    (pos),
    .len_o    (flen)
  );

  // channel 0 carries the mono pick (or left in mix), channel 1 the right slot
  logic [3:0]  ch_slot [NUM_CH];
  logic [31:0] ch_word [NUM_CH];
  logic        ch_null [NUM_CH];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) ch_slot[c] = cfg_right_slot_i;
    case (src)
      SRC_DEV:   ch_slot[0] = dev_slot_i;
      SRC_RIGHT: ch_slot[0] = cfg_right_slot_i;
      default:   ch_slot[0] = cfg_left_slot_i;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdmrx_slot_capture #(.PW(PW), .LW(LW)) u_cap (
      .clk         (clk),
      .rst_n       (rst_l),
      .bit_stb_i   (bit_stb),
      .sd_bit_i    (sd_bit),
      .start_i     (start),
      .pos_i       (pos),
      .len_i       (flen),
      .slot_i      (ch_slot[c]),
      .offset_i    (cfg_offset_i),
      .slot_bits_i (sbits),
      .eff_bits_i  (ebits),
      .right_just_i(cfg_right_just_i),
      .word_o      (ch_word[c]),
      .null_o      (ch_null[c])
    );
  end

  // down-mix in one extra bit, then arithmetic halving
  logic signed [32:0] mix_sum;
  logic [31:0]        smp_d;
  logic               null_d;

  always_comb begin
    mix_sum = $signed({ch_word[0][31], ch_word[0]}) + $signed({ch_word[1][31], ch_word[1]});
    if (src == SRC_MIX) begin
      smp_d  = mix_sum[32:1];
      null_d = ch_null[0] | ch_null[1];
    end else begin
      smp_d  = ch_word[0];
      null_d = ch_null[0];
    end
  end

  logic [31:0] smp_q;
  logic        valid_q, null_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      smp_q   <= '0;
      null_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) begin
        smp_q  <= smp_d;
        null_q <= null_d;
      end
    end
  end

  assign smp_o       = smp_q;
  assign smp_valid_o = valid_q;
  assign smp_null_o  = null_q;

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_l)
    smp_valid_o |=> !smp_valid_o);

  p_valid_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_l)
    smp_valid_o |-> $past(bit_stb));

  p_null_silent_r9: assert property (@(posedge clk) disable iff (!rst_l)
    (smp_valid_o && smp_null_o && (src != SRC_MIX)) |-> (smp_o == 32'd0));

  p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_l)
    (smp_valid_o && (src != SRC_MIX)) |-> ((smp_o & (32'hFFFF_FFFF >> ebits)) == 32'd0));

endmodule

// File: tb/tdm_rx_slot_selector_bench.sv
module tdm_rx_slot_selector_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic        cfg_fall = 1'b1, cfg_capf = 1'b0, cfg_rj = 1'b0;
  logic [4:0]  cfg_off = 5'd1;
  logic [1:0]  cfg_slen = 2'd2, cfg_wlen = 2'd2, cfg_src = 2'd0;
  logic [3:0]  cfg_ls = 4'd0, cfg_rs = 4'd1, cfg_dev = 4'd0;
  logic [31:0] smp_o;
  logic        smp_valid_o, smp_null_o;

  tdm_rx_slot_selector u_tdm_rx_slot_selector (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .cfg_fs_fall_i(cfg_fall), .cfg_cap_fall_i(cfg_capf), .cfg_offset_i(cfg_off),
    .cfg_slot_len_i(cfg_slen), .cfg_word_len_i(cfg_wlen), .cfg_right_just_i(cfg_rj),
    .cfg_src_i(cfg_src), .cfg_left_slot_i(cfg_ls), .cfg_right_slot_i(cfg_rs),
    .dev_slot_i(cfg_dev), .smp_o(smp_o), .smp_valid_o(smp_valid_o), .smp_null_o(smp_null_o)
  );

  int     n_cmp = 0, n_bad = 0;
  string  tag = "R10";
  longint exp_q[$];
  bit     expn_q[$];
  bit     frm [0:1023];
  int     frm_len = 0;
  longint mon_e;
  bit     mon_n;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R10: actual hung run, expected completion");
    finish_run();
  end

  // behavioural model of one slot of the stored frame
  function automatic void model_slot(input int slot, output longint val, output bit nul);
    int sb, wb, w, st;
    longint u, wu;
    sb = (cfg_slen == 2'd0) ? 16 : (cfg_slen == 2'd1) ? 24 : 32;
    case (cfg_wlen)
      2'd0: wb = 16;
      2'd1: wb = 20;
      2'd2: wb = 24;
      default: wb = 32;
    endcase
    w  = (wb < sb) ? wb : sb;
    st = int'(cfg_off) + slot * sb;
    if (st + sb > frm_len) begin
      val = 0; nul = 1'b1;
      return;
    end
    u = 0;
    for (int i = 0; i < sb; i++) u = (u << 1) | longint'(frm[st + i]);
    if (cfg_rj) wu = u & ((longint'(1) << w) - 1);
    else        wu = u >> (sb - w);
    if (((wu >> (w - 1)) & 1) == 1) wu = wu - (longint'(1) << w);
    val = wu * (longint'(1) << (32 - w));
    nul = 1'b0;
  endfunction

  task automatic push_expect();
    longint a, b;
    bit na, nb;
    case (cfg_src)
      2'd0: model_slot(int'(cfg_dev), a, na);
      2'd1: model_slot(int'(cfg_ls), a, na);
      2'd2: model_slot(int'(cfg_rs), a, na);
      default: begin
        model_slot(int'(cfg_ls), a, na);
        model_slot(int'(cfg_rs), b, nb);
        a  = (a + b) >>> 1;
        na = na | nb;
      end
    endcase
    exp_q.push_back(a);
    expn_q.push_back(na);
  endtask

  // output monitor, compared away from the active edge
  always @(negedge clk) begin
    if (rst_n && smp_valid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: actual valid with sample %h, expected no valid (R10)", tag, smp_o);
      end else begin
        mon_e = exp_q.pop_front();
        mon_n = expn_q.pop_front();
        if (smp_o !== 32'(mon_e) || smp_null_o !== mon_n) begin
          n_bad++;
          $display("FAIL %s: actual %h null %0b, expected %h null %0b",
                   tag, smp_o, smp_null_o, 32'(mon_e), mon_n);
        end
      end
    end
  end

  task automatic drive_bit(input bit fs, input bit sd);
    @(negedge clk);
    bclk = cfg_capf ? 1'b1 : 1'b0;
    fsync = fs;
    sdata = sd;
    repeat (2) @(negedge clk);
    bclk = cfg_capf ? 1'b0 : 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input int nbits, input bit record);
    bit act;
    act = ~cfg_fall;
    frm_len = nbits;
    for (int i = 0; i < nbits; i++) frm[i] = 1'($urandom);
    if (record) push_expect();
    for (int i = 0; i < nbits; i++) drive_bit((i < nbits / 2) ? act : ~act, frm[i]);
  endtask

  task automatic run_case(input string t, input bit fall, input bit capf, input int off,
                          input int sl, input int wl, input bit rj, input int src,
                          input int ls, input int rs, input int dev,
                          input int nbits, input int nfr);
    rst_n = 1'b0;
    @(negedge clk);
    tag = t;
    bclk = 1'b0;
    cfg_fall = fall; cfg_capf = capf; cfg_off = 5'(off);
    cfg_slen = 2'(sl); cfg_wlen = 2'(wl); cfg_rj = rj; cfg_src = 2'(src);
    cfg_ls = 4'(ls); cfg_rs = 4'(rs); cfg_dev = 4'(dev);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) drive_bit(fall, 1'b0);
    for (int f = 0; f < nfr; f++) send_frame(nbits, 1'b1);
    send_frame(4, 1'b0);
    repeat (20) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s R10: actual %0d samples missing, expected 0", t, exp_q.size());
    end
    exp_q.delete();
    expn_q.delete();
  endtask

  initial begin
    // reset state (R10)
    repeat (3) @(negedge clk);
    n_cmp++;
    if (smp_o !== 32'd0 || smp_valid_o !== 1'b0 || smp_null_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: actual %h/%0b/%0b, expected 0/0/0", smp_o, smp_valid_o, smp_null_o);
    end
    // polarity, edge, offset, slot and word lengths, device slot
    run_case("R1 R2 R3 R4 R5 R7 defaults", 1, 0, 1, 2, 2, 0, 0, 0, 1, 2, 128, 3);
    run_case("R1 R2 R4 R7 rising sync, falling edge", 0, 1, 0, 0, 0, 0, 1, 3, 0, 0, 64, 3);
    run_case("R3 R6 R7 right justified 20 in 24", 1, 1, 5, 1, 1, 1, 2, 0, 2, 0, 96, 3);
    run_case("R8 down-mix 32-bit", 1, 0, 1, 2, 3, 0, 3, 0, 1, 0, 72, 4);
    run_case("R9 slot past frame end", 1, 0, 1, 2, 2, 0, 1, 1, 0, 0, 64, 2);
    run_case("R8 R9 mix with one null", 1, 0, 1, 2, 2, 0, 3, 0, 1, 0, 64, 2);
    run_case("R5 word clipped to slot", 0, 0, 0, 0, 2, 0, 1, 2, 0, 0, 64, 2);
    run_case("R3 R6 offset 31", 1, 0, 31, 0, 3, 1, 0, 0, 0, 0, 64, 2);
    run_case("R4 R6 24-bit slot right", 0, 1, 2, 1, 0, 1, 2, 0, 3, 0, 128, 2);
    run_case("R9 R7 slot ends on frame end", 1, 0, 0, 0, 2, 0, 0, 0, 0, 15, 256, 2);
    run_case("R9 R7 slot one bit past end", 1, 0, 1, 0, 2, 0, 0, 0, 0, 15, 256, 2);
    finish_run();
  end

endmodule